// File: doc/BRIEF.md
# BCD Calendar Counter Chain

This block keeps wall-clock time and date as packed BCD fields. The fields are seconds, minutes, hours, day of month, weekday, month and a two-digit year, plus a century bit. A one-cycle 1 Hz `tick` moves the whole chain forward. Every carry from seconds up to the century bit settles in the same clock cycle. Day lengths follow the month, and February has a leap day in years divisible by four.

A host bus block reaches the fields through a register-style write port and a combinational read port. While the host runs a bus transfer, it holds `freeze` high so that the values it reads stay consistent. Ticks that arrive during the freeze are not lost without trace: one of them is remembered and applied after release. A sticky integrity flag records low-supply or oscillator-stop events until the host clears it.

Top module: `bcd_calendar`

## Requirements
- R1: Register map. Address 0 holds seconds in bits 6:0 (00–59). Address 1 holds minutes in bits 6:0 (00–59). Address 2 holds hours in bits 5:0 (00–23). Address 3 holds the day of month in bits 5:0 (01–31). Address 4 holds the weekday in bits 2:0. Address 5 holds the month in bits 4:0 (01–12). Address 6 holds the year in bits 7:0 (00–99). Each field wraps to its lowest value after its highest and carries into the next field.
- R2: Bit 7 of address 5 is the century bit. It toggles when the year advances from 99 to 00.
- R3: February ends on day 29 when the BCD year is divisible by four, year 00 included, and on day 28 otherwise.
- R4: While `freeze` is high, no field advances, and any number of ticks leave exactly one pending. In the first cycle with `freeze` low, the pending tick advances the chain once. If a new tick arrives in that same cycle, it stays pending and is applied in the next cycle.
- R5: Bit 7 of address 0 is the integrity flag. It is set by reset and by `integ_evt`, which takes effect on the next edge. A write to address 0 with bit 7 = 0 clears it. A write with bit 7 = 1 never sets it. `integ_evt` wins over a clearing write in the same cycle.
- R6: The weekday advances once for each day advance and wraps from 6 to 0. It is independent of the date, and the host may write any value to it.
- R7: Unimplemented bits read as 0 and are ignored on write. Address 7 reads 00, and writes to it change nothing.
- R8: A tick at 23:59:59 on the last day of a month updates every affected field, up to the year and the century bit, in one cycle.
- R9: April, June, September and November end on day 30. The remaining months other than February end on day 31.
- R10: A host write to a field takes priority over an increment or carry into that field in the same cycle.
- R11: Reset value: 00:00:00, day 01, weekday 0, month 01, century 0, year 00, integrity flag 1.
- R12: A `tick` sampled high at a clock edge when not frozen changes the fields at that same edge. The new values can be read in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle 1 Hz advance strobe |
| freeze | input | 1 | High while a host access is in progress |
| integ_evt | input | 1 | Low-supply or oscillator-stop event |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | 3 | Field write address |
| wr_data | input | 8 | Field write data |
| rd_addr | input | 3 | Field read address |
| rd_data | output | 8 | Field read data (combinational) |

## Verification
The assertions watch several properties on every cycle. No field moves during a freeze without a write, and the pending tick is dropped once an unfrozen cycle passes without a tick. They also check that the integrity flag can only fall through a clearing write, that a host write to minutes lands regardless of any carry, and that the final carry of a century toggles the century bit. Other behaviour needs the bench's scenarios and its per-cycle reference model. These are the leap-year and month-length boundaries, the full one-cycle ripple, weekday wrap, the coincident-release tick, masked bits and write-over-tick priority.

// File: rtl/bcd_calendar.sv
`timescale 1ns/100ps
module bcd_calendar (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       freeze,
  input  logic       integ_evt,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data
);
  localparam logic [2:0] A_SEC = 3'd0, A_MIN = 3'd1, A_HR = 3'd2, A_DAY = 3'd3,
                         A_WD = 3'd4, A_MON = 3'd5, A_YR = 3'd6;

  logic [6:0] sec, min;
  logic [5:0] hr, day;
  logic [2:0] wd;
  logic [4:0] mon;
  logic [7:0] yr;
  logic       cent, flag, pend;

  function automatic logic [7:0] bcd_next(input logic [7:0] v);
    return (v[3:0] >= 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  logic [7:0] n_sec, n_min, n_hr, n_day, n_mon, n_yr;
  assign n_sec = bcd_next({1'b0, sec});
  assign n_min = bcd_next({1'b0, min});
  assign n_hr  = bcd_next({2'b0, hr});
  assign n_day = bcd_next({2'b0, day});
  assign n_mon = bcd_next({3'b0, mon});
  assign n_yr  = bcd_next(yr);

  logic advance, leap, short_mon;
  logic [5:0] last_day;
  assign advance   = !freeze && (tick || pend);
  assign leap      = yr[4] ? (yr[3:0] == 4'h2 || yr[3:0] == 4'h6) : (yr[1:0] == 2'b00);
  assign short_mon = (mon == 5'h04) || (mon == 5'h06) || (mon == 5'h09) || (mon == 5'h11);
  assign last_day  = (mon == 5'h02) ? (leap ? 6'h29 : 6'h28) : (short_mon ? 6'h30 : 6'h31);

  logic c_sec, c_min, c_hr, c_day, c_mon;
  assign c_sec = advance && (sec >= 7'h59);
  assign c_min = c_sec && (min >= 7'h59);
  assign c_hr  = c_min && (hr >= 6'h23);
  assign c_day = c_hr && (day >= last_day);
  assign c_mon = c_day && (mon >= 5'h12);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec <= '0; min <= '0; hr <= '0; day <= 6'h01; wd <= '0;
      mon <= 5'h01; yr <= '0; cent <= 1'b0; pend <= 1'b0;
    end else begin
      pend <= freeze ? (pend || tick) : (pend && tick);
      if (advance) sec <= c_sec ? 7'h00 : n_sec[6:0];
      if (c_sec)   min <= c_min ? 7'h00 : n_min[6:0];
      if (c_min)   hr  <= c_hr  ? 6'h00 : n_hr[5:0];
      if (c_hr) begin
        day <= c_day ? 6'h01 : n_day[5:0];
        wd  <= (wd >= 3'd6) ? 3'd0 : wd + 3'd1;
      end
      if (c_day) mon <= c_mon ? 5'h01 : n_mon[4:0];
      if (c_mon) begin
        yr <= (yr >= 8'h99) ? 8'h00 : n_yr;
        if (yr >= 8'h99) cent <= !cent;
      end
      if (wr_en) begin
        case (wr_addr)
          A_SEC: sec <= wr_data[6:0];
          A_MIN: min <= wr_data[6:0];
          A_HR:  hr  <= wr_data[5:0];
          A_DAY: day <= wr_data[5:0];
          A_WD:  wd  <= wr_data[2:0];
          A_MON: begin mon <= wr_data[4:0]; cent <= wr_data[7]; end
          A_YR:  yr  <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                            flag <= 1'b1;
    else if (integ_evt)                                    flag <= 1'b1;
    else if (wr_en && wr_addr == A_SEC && !wr_data[7])     flag <= 1'b0;
  end

  always_comb begin
    case (rd_addr)
      A_SEC:   rd_data = {flag, sec};
      A_MIN:   rd_data = {1'b0, min};
      A_HR:    rd_data = {2'b0, hr};
      A_DAY:   rd_data = {2'b0, day};
      A_WD:    rd_data = {5'b0, wd};
      A_MON:   rd_data = {cent, 2'b0, mon};
      A_YR:    rd_data = yr;
      default: rd_data = 8'h00;
    endcase
  end

  p_hold_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    freeze && !wr_en |=> {sec, min, hr, day, wd, mon, cent, yr} ==
                         $past({sec, min, hr, day, wd, mon, cent, yr}));

  p_pending_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !freeze && !tick |=> !pend);

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !(wr_en && wr_addr == A_SEC) |=> flag);

  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == A_MIN |=> min == $past(wr_data[6:0]));

  p_century_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !wr_en && sec == 7'h59 && min == 7'h59 && hr == 6'h23 &&
    day == 6'h31 && mon == 5'h12 && yr == 8'h99
    |=> cent != $past(cent) && yr == 8'h00 && mon == 5'h01);
endmodule

// File: tb/sim_bcd_calendar.sv
`timescale 1ns/100ps
module sim_bcd_calendar;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, freeze = 1'b0, integ_evt = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  bcd_calendar u0 (.clk, .rst_n, .tick, .freeze, .integ_evt, .wr_en, .wr_addr,
                   .wr_data, .rd_addr, .rd_data);

  always #10 clk = ~clk;

  // reference model, BCD bytes
  logic [7:0] m_sec, m_min, m_hr, m_day, m_wd, m_mon, m_yr;
  bit m_cent, m_flag, m_pend;

  function automatic int b2i(logic [7:0] b); return b[7:4] * 10 + b[3:0]; endfunction
  function automatic logic [7:0] i2b(int i); return {4'(i / 10), 4'(i % 10)}; endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sec = 0; m_min = 0; m_hr = 0; m_day = 8'h01; m_wd = 0; m_mon = 8'h01;
      m_yr = 0; m_cent = 0; m_flag = 1; m_pend = 0;
    end else begin
      bit adv, cy;
      int lim, y, mo;
      adv = !freeze && (tick || m_pend);
      m_pend = freeze ? (m_pend || tick) : (m_pend && tick);
      cy = adv;
      if (cy) begin
        if (b2i(m_sec) >= 59) m_sec = 0; else begin m_sec = i2b(b2i(m_sec) + 1); cy = 0; end
      end
      if (cy) begin
        if (b2i(m_min) >= 59) m_min = 0; else begin m_min = i2b(b2i(m_min) + 1); cy = 0; end
      end
      if (cy) begin
        if (b2i(m_hr) >= 23) m_hr = 0; else begin m_hr = i2b(b2i(m_hr) + 1); cy = 0; end
      end
      if (cy) begin
        m_wd = (m_wd >= 6) ? 0 : m_wd + 1;
        y = b2i(m_yr); mo = b2i(m_mon);
        lim = (mo == 2) ? ((y % 4 == 0) ? 29 : 28) :
              (mo == 4 || mo == 6 || mo == 9 || mo == 11) ? 30 : 31;
        if (b2i(m_day) >= lim) m_day = 8'h01; else begin m_day = i2b(b2i(m_day) + 1); cy = 0; end
      end
      if (cy) begin
        if (b2i(m_mon) >= 12) m_mon = 8'h01; else begin m_mon = i2b(b2i(m_mon) + 1); cy = 0; end
      end
      if (cy) begin
        if (b2i(m_yr) >= 99) begin m_yr = 0; m_cent = !m_cent; end
        else m_yr = i2b(b2i(m_yr) + 1);
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_sec = {1'b0, wr_data[6:0]};
          3'd1: m_min = {1'b0, wr_data[6:0]};
          3'd2: m_hr  = {2'b0, wr_data[5:0]};
          3'd3: m_day = {2'b0, wr_data[5:0]};
          3'd4: m_wd  = {5'b0, wr_data[2:0]};
          3'd5: begin m_mon = {3'b0, wr_data[4:0]}; m_cent = wr_data[7]; end
          3'd6: m_yr  = wr_data;
          default: ;
        endcase
      end
      if (integ_evt) m_flag = 1;
      else if (wr_en && wr_addr == 3'd0 && !wr_data[7]) m_flag = 0;
    end
  end

  function automatic logic [7:0] m_read(int a);
    case (a)
      0: return {m_flag, m_sec[6:0]};
      1: return m_min;
      2: return m_hr;
      3: return m_day;
      4: return m_wd;
      5: return {m_cent, m_mon[6:0]};
      6: return m_yr;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(logic [7:0] act, logic [7:0] exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      for (int a = 0; a < 8; a++) begin
        rd_addr = 3'(a);
        #1;
        check(rd_data, m_read(a),
              a == 0 ? "R5 model sec" : a == 5 ? "R2 model month" :
              a == 7 ? "R7 model addr7" : "R1 model field");
      end
    end
  end

  task automatic peek(int a, logic [7:0] exp, string tag);
    @(negedge clk); #9;
    rd_addr = 3'(a);
    #0.5;
    check(rd_data, exp, tag);
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse;
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic set_all(logic [7:0] s, logic [7:0] mi, logic [7:0] h, logic [7:0] d,
                         logic [7:0] w, logic [7:0] mo, logic [7:0] y);
    wr(0, s); wr(1, mi); wr(2, h); wr(3, d); wr(4, w); wr(5, mo); wr(6, y);
  endtask

  task automatic eod(logic [7:0] d, logic [7:0] mo, logic [7:0] y,
                     logic [7:0] ed, logic [7:0] emo, string tag);
    set_all(8'h59, 8'h59, 8'h23, d, 8'h02, mo, y);
    pulse;
    peek(3, ed, tag);
    peek(5, emo, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    peek(0, 8'h80, "R11 sec/flag"); peek(1, 8'h00, "R11 min");
    peek(2, 8'h00, "R11 hr");       peek(3, 8'h01, "R11 day");
    peek(4, 8'h00, "R11 wd");       peek(5, 8'h01, "R11 month");
    peek(6, 8'h00, "R11 year");     peek(7, 8'h00, "R7 addr7");
    // R12 single tick
    pulse; peek(0, 8'h81, "R12 tick");
    // R5 integrity flag
    wr(0, 8'h00); peek(0, 8'h00, "R5 clear");
    wr(0, 8'h85); peek(0, 8'h05, "R5 no set by write");
    @(negedge clk); integ_evt = 1; @(negedge clk); integ_evt = 0;
    peek(0, 8'h85, "R5 event sets");
    wr(0, 8'h86); peek(0, 8'h86, "R5 sticky");
    @(negedge clk); integ_evt = 1; wr_en = 1; wr_addr = 0; wr_data = 8'h07;
    @(negedge clk); integ_evt = 0; wr_en = 0;
    peek(0, 8'h87, "R5 event beats clear");
    wr(0, 8'h07); peek(0, 8'h07, "R5 clear again");
    // R8 R2 R6 full ripple
    set_all(8'h59, 8'h59, 8'h23, 8'h31, 8'h06, 8'h12, 8'h99);
    pulse;
    peek(0, 8'h00, "R8 sec"); peek(1, 8'h00, "R8 min"); peek(2, 8'h00, "R8 hr");
    peek(3, 8'h01, "R8 day"); peek(4, 8'h00, "R6 weekday wrap");
    peek(5, 8'h81, "R2 century"); peek(6, 8'h00, "R8 year");
    // R3 leap years
    eod(8'h28, 8'h02, 8'h04, 8'h29, 8'h02, "R3 year 04");
    eod(8'h29, 8'h02, 8'h04, 8'h01, 8'h03, "R3 year 04 end");
    eod(8'h28, 8'h02, 8'h00, 8'h29, 8'h02, "R3 year 00");
    eod(8'h28, 8'h02, 8'h12, 8'h29, 8'h02, "R3 year 12");
    eod(8'h28, 8'h02, 8'h01, 8'h01, 8'h03, "R3 year 01");
    eod(8'h28, 8'h02, 8'h10, 8'h01, 8'h03, "R3 year 10");
    // R9 month lengths
    eod(8'h30, 8'h04, 8'h21, 8'h01, 8'h05, "R9 april");
    eod(8'h30, 8'h09, 8'h21, 8'h01, 8'h10, "R9 september");
    eod(8'h30, 8'h01, 8'h21, 8'h31, 8'h01, "R9 january");
    eod(8'h31, 8'h07, 8'h21, 8'h01, 8'h08, "R9 july");
    // R6 weekday advance
    set_all(8'h59, 8'h59, 8'h23, 8'h10, 8'h03, 8'h05, 8'h21);
    pulse; peek(4, 8'h04, "R6 weekday step");
    // R4 freeze with several ticks
    wr(0, 8'h10);
    @(negedge clk); freeze = 1;
    pulse; pulse; pulse;
    peek(0, 8'h10, "R4 held");
    @(negedge clk); freeze = 0;
    peek(0, 8'h11, "R4 one pending applied");
    peek(0, 8'h11, "R4 only one");
    // R4 tick during release cycle
    wr(0, 8'h20);
    @(negedge clk); freeze = 1;
    pulse;
    @(negedge clk); freeze = 0; tick = 1;
    @(negedge clk); tick = 0;
    peek(0, 8'h22, "R4 release tick kept");
    // R10 write over tick
    @(negedge clk); tick = 1; wr_en = 1; wr_addr = 0; wr_data = 8'h30;
    @(negedge clk); tick = 0; wr_en = 0;
    peek(0, 8'h30, "R10 sec write wins");
    wr(0, 8'h59); wr(1, 8'h05);
    @(negedge clk); tick = 1; wr_en = 1; wr_addr = 1; wr_data = 8'h10;
    @(negedge clk); tick = 0; wr_en = 0;
    peek(0, 8'h00, "R10 sec wrapped");
    peek(1, 8'h10, "R10 min write wins");
    // R7 unimplemented bits
    wr(2, 8'hD3); peek(2, 8'h13, "R7 hour mask");
    wr(4, 8'hFD); peek(4, 8'h05, "R7 R6 weekday mask");
    wr(5, 8'h72); peek(5, 8'h12, "R7 month mask");
    wr(7, 8'hFF); peek(7, 8'h00, "R7 addr7 write");
    peek(0, 8'h00, "R7 others untouched");
    repeat (4) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule